// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Sequencer

This controller sits beside a static RAM that has a nonvolatile shadow copy. It watches the RAM port and recognises a read access as one low pulse of chip enable. When it sees a fixed run of six read accesses, it starts one of two cycles. A STORE copies the SRAM into the shadow cells. A RECALL copies the shadow cells back into the SRAM. Five parameter addresses open the run. The address of the sixth read chooses the operation. Once a cycle has started, it runs for a fixed number of clocks and the port cannot disturb it. During that time the data bus is held at high impedance.

The block also watches a supply-good flag. When the flag rises while the block waits for supply, a RECALL starts on its own. This happens after reset and after a power loss. A STORE is cut short, with an abort pulse, if the supply flag drops while the STORE runs. A RECALL always runs to the end.

The controller state machine has four states:
- WAIT_SUPPLY (`ST_PWRWAIT`) is the reset state.
  - It moves to RECALL when supply is good.
- READY (`ST_READY`)
  - It moves back to WAIT_SUPPLY when supply is lost.
  - It moves to STORE or RECALL when the unlock matcher reports an operation.
- STORE (`ST_STORE`)
  - It moves to READY with a done pulse when its count runs out.
  - It moves to WAIT_SUPPLY with an abort pulse when supply drops.
- RECALL (`ST_RECALL`)
  - It moves to READY with a done pulse when its count runs out.

Top module: `nvsram_cycle_ctrl`

## Requirements
- R1: While reset is held, busy, store_active, recall_active, out_hiz, done_pulse and abort_pulse are all 0. After reset, if supply_ok stays 0, they all stay 0.
- R2: In WAIT_SUPPLY, supply_ok = 1 starts a RECALL on the next clock. No address run is needed. This applies after reset and after an aborted STORE.
- R3: The block counts a read access when ce_n has been sampled low on one or more clocks and is then sampled high again, and we_n was 1 on every low sample. The address is the one sampled on the first low clock. The read addresses SEQ[0]..SEQ[4] followed by MODE_STORE_ADDR start a STORE. The same five followed by MODE_RECALL_ADDR start a RECALL.
- R4: An access with we_n sampled 0 while ce_n is low is a write. A write returns the matcher to step 0.
- R5: A read whose address equals the previous read's address returns the matcher to step 0. It never counts as a step, even when the address is SEQ[0].
- R6: A read that does not match the expected next address returns the matcher to step 0. If that address equals SEQ[0], it counts as step 1 instead.
- R7: While busy is 1, all accesses are ignored. A full address run given during a cycle neither starts a new cycle nor leaves partial progress behind.
- R8: busy stays high for exactly STORE_CYC clocks during a STORE and exactly RECALL_CYC clocks during a RECALL. done_pulse is then high for one clock, on the first clock after busy falls.
- R9: out_hiz is 1 exactly while a STORE or a RECALL runs.
- R10: If supply_ok is 0 during a STORE, then on the next clock abort_pulse is 1 for one clock, busy is 0, and no done_pulse follows.
- R11: A RECALL ignores supply_ok. It always ends with done_pulse after RECALL_CYC clocks.
- R12: store_active and recall_active are never both 1. done_pulse and abort_pulse are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low; each low pulse is one access |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | RAM address |
| supply_ok | input | 1 | Supply above the switching threshold |
| busy | output | 1 | A STORE or RECALL is running |
| store_active | output | 1 | A STORE is running |
| recall_active | output | 1 | A RECALL is running |
| out_hiz | output | 1 | Forces the data bus to high impedance |
| done_pulse | output | 1 | One-clock pulse when a cycle ends normally |
| abort_pulse | output | 1 | One-clock pulse when a STORE is cut short |

## Verification
Each kind of internal fault shows at the ports in its own way:
- A wrong matcher step shows as a missing or unwanted cycle start. It appears two clocks after the sixth read's chip-enable pulse ends.
- A wrong cycle counter shows as a busy window of the wrong length. It appears at the clock where done_pulse is expected.
- A wrong state after a supply drop shows as an abort on a RECALL, or as a missing automatic RECALL. It appears one clock after supply_ok changes.

The scoreboard pairs every start, done and abort pulse with its expected event. It also measures each busy window against its parameter.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
    localparam int PRE_LEN = 5;

    typedef enum logic [1:0] {
        ST_PWRWAIT,
        ST_READY,
        ST_STORE,
        ST_RECALL
    } nvc_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_STORE,
        OP_RECALL
    } nvc_op_e;
endpackage

// File: rtl/nvc_access_detect.sv
module nvc_access_detect #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output logic          acc_valid,
    output logic          acc_write,
    output logic [AW-1:0] acc_addr
);
    logic          in_acc;
    logic          wr_seen;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_acc    <= 1'b0;
            wr_seen   <= 1'b0;
            addr_q    <= '0;
            acc_valid <= 1'b0;
            acc_write <= 1'b0;
        end else begin
            acc_valid <= 1'b0;
            if (!ce_n) begin
                if (!in_acc) begin
                    in_acc  <= 1'b1;
                    addr_q  <= addr;
                    wr_seen <= !we_n;
                end else if (!we_n) begin
                    wr_seen <= 1'b1;
                end
            end else if (in_acc) begin
                in_acc    <= 1'b0;
                acc_valid <= 1'b1;
                acc_write <= wr_seen;
            end
        end
    end

    assign acc_addr = addr_q;

    // R3: an access is reported as a single-clock event
    p_acc_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> !acc_valid);
endmodule

// File: rtl/nvc_unlock_matcher.sv
module nvc_unlock_matcher
    import nvc_pkg::*;
#(
    parameter int                                   AW               = 11,
    parameter logic [nvc_pkg::PRE_LEN-1:0][AW-1:0]  SEQ_ADDR         = {11'h5A5, 11'h7C0, 11'h03F, 11'h31C, 11'h4E3},
    parameter logic [AW-1:0]                        MODE_STORE_ADDR  = 11'h0FC,
    parameter logic [AW-1:0]                        MODE_RECALL_ADDR = 11'h4C3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [AW-1:0] acc_addr,
    output nvc_op_e       op
);
    localparam int SW = $clog2(PRE_LEN + 1);

    logic [SW-1:0]      step;
    logic [AW-1:0]      last_addr;
    logic               last_ok;
    logic [PRE_LEN-1:0] hit;
    logic [2**SW-1:0]   hit_ext;
    logic               is_repeat, step_hit, mode_st, mode_rc;

    for (genvar i = 0; i < PRE_LEN; i++) begin : g_cmp
        assign hit[i] = (acc_addr == SEQ_ADDR[i]);
    end

    always_comb begin
        hit_ext   = (2**SW)'(hit);
        is_repeat = last_ok && (acc_addr == last_addr);
        step_hit  = (step < SW'(PRE_LEN)) && hit_ext[step];
        mode_st   = (step == SW'(PRE_LEN)) && (acc_addr == MODE_STORE_ADDR);
        mode_rc   = (step == SW'(PRE_LEN)) && (acc_addr == MODE_RECALL_ADDR);
        op        = OP_NONE;
        if (acc_valid && !acc_write && !is_repeat && !clear) begin
            if (mode_st)      op = OP_STORE;
            else if (mode_rc) op = OP_RECALL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            step      <= '0;
            last_addr <= '0;
            last_ok   <= 1'b0;
        end else if (acc_valid) begin
            if (acc_write) begin
                step    <= '0;
                last_ok <= 1'b0;
            end else begin
                last_addr <= acc_addr;
                last_ok   <= 1'b1;
                if (is_repeat)            step <= '0;
                else if (step_hit)        step <= step + 1'b1;
                else if (mode_st || mode_rc) step <= '0;
                else                      step <= hit[0] ? SW'(1) : '0;
            end
        end
    end

    // R4: a write access leaves the matcher at step 0
    p_write_breaks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> (step == '0));
    // R5: a repeated read address leaves the matcher at step 0
    p_repeat_resets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && last_ok && (acc_addr == last_addr)) |=> (step == '0));
endmodule

// File: rtl/nvc_cycle_fsm.sv
module nvc_cycle_fsm
    import nvc_pkg::*;
#(
    parameter int STORE_CYC  = 1000000,
    parameter int RECALL_CYC = 2000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    supply_ok,
    input  nvc_op_e op,
    output logic    ready,
    output logic    busy,
    output logic    store_active,
    output logic    recall_active,
    output logic    out_hiz,
    output logic    done_pulse,
    output logic    abort_pulse
);
    localparam int MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ST_LOAD = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] RC_LOAD = CW'(RECALL_CYC - 1);

    nvc_state_e    state, nstate;
    logic [CW-1:0] cnt, ncnt;
    logic          done_q, abort_q, ndone, nabort;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_PWRWAIT;
            cnt     <= '0;
            done_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            state   <= nstate;
            cnt     <= ncnt;
            done_q  <= ndone;
            abort_q <= nabort;
        end
    end

    always_comb begin
        nstate = state;
        ncnt   = cnt;
        ndone  = 1'b0;
        nabort = 1'b0;
        unique case (state)
            ST_PWRWAIT: begin
                if (supply_ok) begin
                    nstate = ST_RECALL;
                    ncnt   = RC_LOAD;
                end
            end
            ST_READY: begin
                if (!supply_ok) begin
                    nstate = ST_PWRWAIT;
                end else if (op == OP_STORE) begin
                    nstate = ST_STORE;
                    ncnt   = ST_LOAD;
                end else if (op == OP_RECALL) begin
                    nstate = ST_RECALL;
                    ncnt   = RC_LOAD;
                end
            end
            ST_STORE: begin
                if (!supply_ok) begin
                    nstate = ST_PWRWAIT;
                    nabort = 1'b1;
                end else if (cnt == '0) begin
                    nstate = ST_READY;
                    ndone  = 1'b1;
                end else begin
                    ncnt = cnt - 1'b1;
                end
            end
            ST_RECALL: begin
                if (cnt == '0) begin
                    nstate = ST_READY;
                    ndone  = 1'b1;
                end else begin
                    ncnt = cnt - 1'b1;
                end
            end
            default: nstate = ST_PWRWAIT;
        endcase
    end

    always_comb begin
        ready         = (state == ST_READY);
        store_active  = (state == ST_STORE);
        recall_active = (state == ST_RECALL);
        busy          = store_active || recall_active;
        out_hiz       = (state == ST_STORE) || (state == ST_RECALL);
        done_pulse    = done_q;
        abort_pulse   = abort_q;
    end

    // R2: waiting for supply and supply good -> recall next clock
    p_autorecall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWRWAIT && supply_ok) |=> recall_active);
    // R8: a running cycle only leaves with a done or abort pulse
    p_busy_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done_pulse || abort_pulse));
    // R9: bus forced to high impedance while busy
    p_hiz_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> out_hiz);
    // R10: supply loss during store aborts on the next clock
    p_store_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (store_active && !supply_ok) |=> (abort_pulse && !busy));
    // R11: recall keeps running regardless of supply
    p_recall_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (recall_active && cnt != '0) |=> recall_active);
    // R12: mutual exclusion of modes and of completion pulses
    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_active && recall_active) && !(done_pulse && abort_pulse));
endmodule

// File: rtl/nvsram_cycle_ctrl.sv
module nvsram_cycle_ctrl
    import nvc_pkg::*;
#(
    parameter int                                   AW               = 11,
    parameter logic [nvc_pkg::PRE_LEN-1:0][AW-1:0]  SEQ_ADDR         = {11'h5A5, 11'h7C0, 11'h03F, 11'h31C, 11'h4E3},
    parameter logic [AW-1:0]                        MODE_STORE_ADDR  = 11'h0FC,
    parameter logic [AW-1:0]                        MODE_RECALL_ADDR = 11'h4C3,
    parameter int                                   STORE_CYC        = 1000000,
    parameter int                                   RECALL_CYC       = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic          supply_ok,
    output logic          busy,
    output logic          store_active,
    output logic          recall_active,
    output logic          out_hiz,
    output logic          done_pulse,
    output logic          abort_pulse
);
    logic          acc_valid, acc_write, ready;
    logic [AW-1:0] acc_addr;
    nvc_op_e       match_op;

    nvc_access_detect #(.AW(AW)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .addr      (addr),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr)
    );

    nvc_unlock_matcher #(
        .AW               (AW),
        .SEQ_ADDR         (SEQ_ADDR),
        .MODE_STORE_ADDR  (MODE_STORE_ADDR),
        .MODE_RECALL_ADDR (MODE_RECALL_ADDR)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!ready),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .op        (match_op)
    );

    nvc_cycle_fsm #(
        .STORE_CYC  (STORE_CYC),
        .RECALL_CYC (RECALL_CYC)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .supply_ok     (supply_ok),
        .op            (match_op),
        .ready         (ready),
        .busy          (busy),
        .store_active  (store_active),
        .recall_active (recall_active),
        .out_hiz       (out_hiz),
        .done_pulse    (done_pulse),
        .abort_pulse   (abort_pulse)
    );

    // R7: while a cycle runs the matcher never requests an operation
    p_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (match_op == OP_NONE));
endmodule

// File: tb/nvsram_cycle_ctrl_tb_top.sv
module nvsram_cycle_ctrl_tb_top;
    localparam int AW = 11;
    localparam logic [4:0][AW-1:0] SEQ = {11'h5A5, 11'h7C0, 11'h03F, 11'h31C, 11'h4E3};
    localparam logic [AW-1:0] M_ST = 11'h0FC;
    localparam logic [AW-1:0] M_RC = 11'h4C3;
    localparam int SCYC = 40;
    localparam int RCYC = 12;

    typedef enum int {EV_ST_START, EV_RC_START, EV_DONE, EV_ABORT} ev_e;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1;
    logic we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic supply_ok = 1'b0;
    logic busy, store_active, recall_active, out_hiz, done_pulse, abort_pulse;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    ev_e   exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    nvsram_cycle_ctrl #(
        .AW(AW), .SEQ_ADDR(SEQ), .MODE_STORE_ADDR(M_ST), .MODE_RECALL_ADDR(M_RC),
        .STORE_CYC(SCYC), .RECALL_CYC(RCYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .supply_ok(supply_ok), .busy(busy), .store_active(store_active),
        .recall_active(recall_active), .out_hiz(out_hiz),
        .done_pulse(done_pulse), .abort_pulse(abort_pulse)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input ev_e e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic access(input logic [AW-1:0] a, input bit is_wr);
        @(negedge clk);
        ce_n = 1'b0; we_n = !is_wr; addr = a;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        cycles(2);
    endtask

    task automatic do_seq(input logic [AW-1:0] mode);
        for (int i = 0; i < 5; i++) access(SEQ[i], 1'b0);
        access(mode, 1'b0);
    endtask

    task automatic idle_chk(input string tag, input int n);
        cycles(n);
        chk(busy == 1'b0, tag, int'(busy), 0);
    endtask

    // monitor: pop and compare expected events
    logic prev_st = 1'b0, prev_rc = 1'b0, last_st = 1'b0;
    int run = 0;

    task automatic see(input ev_e e);
        string t;
        if (exp_q.size() == 0) begin
            chk(1'b0, "unexpected event", int'(e), -1);
        end else begin
            t = tag_q.pop_front();
            chk(exp_q.pop_front() == e, t, int'(e), int'(e));
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_st = 1'b0; prev_rc = 1'b0; run = 0;
        end else begin
            if (store_active && !prev_st) begin
                see(EV_ST_START); run = 0; last_st = 1'b1;
                chk(out_hiz == 1'b1, "R9 hiz at store start", int'(out_hiz), 1);
                chk(!recall_active, "R12 exclusive", int'(recall_active), 0);
            end
            if (recall_active && !prev_rc) begin
                see(EV_RC_START); run = 0; last_st = 1'b0;
                chk(out_hiz == 1'b1, "R9 hiz at recall start", int'(out_hiz), 1);
                chk(!store_active, "R12 exclusive", int'(store_active), 0);
            end
            if (store_active || recall_active) run++;
            if (done_pulse) begin
                see(EV_DONE);
                chk(run == (last_st ? SCYC : RCYC), "R8 busy length", run, last_st ? SCYC : RCYC);
                chk(!busy && !out_hiz, "R9 hiz released", int'(out_hiz), 0);
                chk(!abort_pulse, "R12 done/abort", int'(abort_pulse), 0);
                run = 0;
            end
            if (abort_pulse) begin
                see(EV_ABORT); run = 0;
            end
            prev_st = store_active;
            prev_rc = recall_active;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cycles(3);
        // R1 reset state
        chk({busy, store_active, recall_active, out_hiz, done_pulse, abort_pulse} == 6'b0,
            "R1 reset outputs", int'({busy, store_active, recall_active, out_hiz, done_pulse, abort_pulse}), 0);
        rst_n = 1'b1;
        cycles(5);
        chk({busy, out_hiz, done_pulse} == 3'b0, "R1 no supply idle", int'({busy, out_hiz, done_pulse}), 0);
        // R2 automatic recall at power-up
        push(EV_RC_START, "R2 auto recall"); push(EV_DONE, "R2 recall done");
        supply_ok = 1'b1;
        cycles(RCYC + 6);
        // R3 store by sequence, R7 sequence during busy ignored
        push(EV_ST_START, "R3 store start"); push(EV_DONE, "R8 store done");
        do_seq(M_ST);
        chk(busy && out_hiz, "R9 busy hiz", int'(out_hiz), 1);
        do_seq(M_RC);
        cycles(SCYC);
        access(M_RC, 1'b0);
        idle_chk("R7 no leftover progress", 4);
        // R3 recall by sequence
        push(EV_RC_START, "R3 recall start"); push(EV_DONE, "R8 recall done");
        do_seq(M_RC);
        cycles(RCYC + 6);
        // R4 write breaks the sequence
        access(SEQ[0], 1'b0); access(SEQ[1], 1'b0); access(SEQ[2], 1'b0);
        access(SEQ[3], 1'b1);
        access(SEQ[3], 1'b0); access(SEQ[4], 1'b0); access(M_ST, 1'b0);
        idle_chk("R4 write break", 6);
        // R5 repeated address breaks the sequence
        access(SEQ[0], 1'b0); access(SEQ[1], 1'b0); access(SEQ[1], 1'b0);
        access(SEQ[2], 1'b0); access(SEQ[3], 1'b0); access(SEQ[4], 1'b0); access(M_ST, 1'b0);
        idle_chk("R5 repeat break", 6);
        // R5 repeated first address does not count as step 1
        access(SEQ[0], 1'b0); access(SEQ[0], 1'b0);
        access(SEQ[1], 1'b0); access(SEQ[2], 1'b0); access(SEQ[3], 1'b0); access(SEQ[4], 1'b0);
        access(M_RC, 1'b0);
        idle_chk("R5 repeat first", 6);
        // R6 foreign address resets
        access(SEQ[0], 1'b0); access(SEQ[1], 1'b0); access(11'h123, 1'b0);
        access(SEQ[2], 1'b0); access(SEQ[3], 1'b0); access(SEQ[4], 1'b0); access(M_ST, 1'b0);
        idle_chk("R6 mismatch reset", 6);
        // R6 mismatch equal to first address restarts at step 1
        push(EV_ST_START, "R6 restart store"); push(EV_DONE, "R6 store done");
        access(SEQ[0], 1'b0); access(SEQ[1], 1'b0); access(SEQ[0], 1'b0);
        access(SEQ[1], 1'b0); access(SEQ[2], 1'b0); access(SEQ[3], 1'b0); access(SEQ[4], 1'b0);
        access(M_ST, 1'b0);
        cycles(SCYC + 6);
        // R10 store aborted by supply loss, then R2 recall on re-rise
        push(EV_ST_START, "R10 store start"); push(EV_ABORT, "R10 abort");
        do_seq(M_ST);
        cycles(10);
        supply_ok = 1'b0;
        cycles(3);
        chk(!busy && !store_active, "R10 stopped", int'(busy), 0);
        idle_chk("R10 no restart while low", 5);
        push(EV_RC_START, "R2 recall after abort"); push(EV_DONE, "R2 done after abort");
        supply_ok = 1'b1;
        cycles(RCYC + 6);
        // R11 recall ignores supply drop
        push(EV_RC_START, "R11 recall start"); push(EV_DONE, "R11 recall done");
        do_seq(M_RC);
        cycles(3);
        supply_ok = 1'b0;
        cycles(RCYC + 4);
        chk(!busy, "R11 ended", int'(busy), 0);
        push(EV_RC_START, "R2 recall on rise"); push(EV_DONE, "R2 done on rise");
        supply_ok = 1'b1;
        cycles(RCYC + 6);
        chk(exp_q.size() == 0, "R3 all expected events seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule